// File: doc/BRIEF.md
# Magnetic Stripe Track Decoder

This block serves one track channel of a card reader. It takes a stream of already recovered serial bits from the stripe head front end, one bit per `bit_valid` strobe. It then looks for a start sentinel that the host programs. Once the sentinel is found, the block cuts the stream into characters of a fixed width, which the selected mode sets to 8, 5 or 7 bits. The sentinel and every character after it are written into a 96-entry first-word-fall-through FIFO.

The collection ends when the front end signals the end of the swipe, or when the mode's character limit is reached. At that point the block raises an interrupt, along with a sticky parity flag and a longitudinal check flag. To read a second track in parallel, instantiate the block a second time.

Host sequence: write the mode and start mark while the block is idle, clear any pending interrupt, then pulse `arm`. The block will not arm while an interrupt is still pending. Arming empties the FIFO and clears both error flags.

Top module: `mstd_track_decoder`

## Requirements
- R1: `cfg_mode` selects the character width: 0 gives 8 bits, 1 gives 5 bits, 2 gives 7 bits, and 3 behaves like 0. `cfg_we` loads the mode and the start mark only while `busy` is low. A write while `busy` is high has no effect.
- R2: Bits arrive least significant first. While hunting, on every strobe, the last `width` bits received are compared with the low `width` bits of the start mark, with the earliest of those bits in bit 0. A match counts only once at least `width` bits have arrived since arming.
- R3: `arm` is ignored while `irq` is high. `irq_clr` drops `irq` on the next clock edge.
- R4: The sentinel and each following group of `width` bits are pushed to the FIFO in arrival order. Each is zero-extended to 8 bits, with its first bit in bit 0.
- R5: While collecting, `card_end` finishes the card: `irq` rises on the next edge, `busy` falls, and an incomplete trailing character is dropped. While hunting, `card_end` has no effect.
- R6: A card finishes by itself as soon as the stored character count reaches 72 (mode 0), 40 (mode 1) or 79 (mode 2). Later bits are not stored.
- R7: Every stored character must have an odd number of ones across all `width` bits. If any does not, `parity_err` is set and stays set until the next arm.
- R8: At finish, `lrc_err` is set if the XOR of the low `width`-1 bits of all stored characters (the last stored one included) is nonzero.
- R9: The FIFO holds 96 characters. `rd_data` shows the oldest entry. `rd_en` on an empty FIFO is ignored, and arming empties the FIFO.
- R10: After reset, `irq`, `busy`, `parity_err` and `lrc_err` are low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Character width select |
| cfg_start | input | 8 | Start mark pattern |
| arm | input | 1 | Start hunting for a new card |
| irq_clr | input | 1 | Clear the interrupt |
| bit_valid | input | 1 | Serial bit strobe |
| bit_data | input | 1 | Serial bit value |
| card_end | input | 1 | End of swipe |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 8 | Oldest FIFO entry |
| rd_empty | output | 1 | FIFO empty |
| rd_level | output | 7 | FIFO occupancy |
| irq | output | 1 | Card complete interrupt |
| busy | output | 1 | Hunting or collecting |
| parity_err | output | 1 | Sticky parity error |
| lrc_err | output | 1 | Longitudinal check failed |

## Verification
Some properties are checked on every cycle. These are: the configuration holds steady while the block is busy; an arm is refused while the interrupt is pending; the bit position inside a character stays below the width; the character count stays below the mode limit during collection; and the FIFO never pushes when full or grows past its depth.

Other behaviour can only be shown by the bench's card scenarios, with expected characters computed independently. This covers the sentinel search at each width, the exact characters and their order, dropping a trailing partial character, the automatic stop at the limit, and the values of the parity and longitudinal flags.

// File: rtl/mstd_pkg.sv
package mstd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HUNT    = 2'd1,
    ST_COLLECT = 2'd2
  } mstd_state_e;

  localparam logic [1:0] MODE_W8 = 2'd0;
  localparam logic [1:0] MODE_W5 = 2'd1;
  localparam logic [1:0] MODE_W7 = 2'd2;

  localparam int NARROW_W = 5;
  localparam int MID_W    = 7;

endpackage

// File: rtl/mstd_bit_window.sv
module mstd_bit_window #(
  parameter int CHAR_W = 8,
  parameter int WW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic [WW-1:0]     width,
  output logic [CHAR_W-1:0] win_nx,
  output logic              filled_nx
);

  logic [CHAR_W-1:0] sr_q, sr_d, sr_shift;
  logic [WW-1:0]     fill_q, fill_d, fill_inc, sh;

  always_comb begin
    sr_shift  = {bit_data, sr_q[CHAR_W-1:1]};
    sh        = WW'(CHAR_W) - width;
    win_nx    = sr_shift >> sh;
    fill_inc  = (fill_q == WW'(CHAR_W)) ? fill_q : fill_q + WW'(1);
    filled_nx = (fill_inc >= width);
    sr_d      = sr_q;
    fill_d    = fill_q;
    if (clear) begin
      sr_d   = '0;
      fill_d = '0;
    end else if (bit_valid) begin
      sr_d   = sr_shift;
      fill_d = fill_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else begin
      sr_q   <= sr_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/mstd_char_check.sv
module mstd_char_check #(
  parameter int CHAR_W = 8,
  parameter int WW     = 4
) (
  input  logic [CHAR_W-1:0] ch,
  input  logic [WW-1:0]     width,
  output logic              par_ok,
  output logic [CHAR_W-1:0] data
);

  assign par_ok = ^ch;

  for (genvar g = 0; g < CHAR_W; g++) begin : g_mask
    assign data[g] = ch[g] & ((WW'(g) + WW'(1)) < width);
  end

endmodule

// File: rtl/mstd_fifo.sv
module mstd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 96,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic [LW-1:0] level
);

  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LW'(DEPTH));
  assign level   = lvl_q;
  assign rd_data = mem[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + LW'(1);
        2'b01:   lvl_d = lvl_q - LW'(1);
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_q] <= push_data;
  end

  // R9: a push never meets a full store
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: occupancy never passes the depth
  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));

endmodule

// File: rtl/mstd_track_decoder.sv
module mstd_track_decoder
  import mstd_pkg::*;
#(
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 96,
  parameter int MAX_W8     = 72,
  parameter int MAX_W5     = 40,
  parameter int MAX_W7     = 79,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [CHAR_W-1:0] cfg_start,
  input  logic              arm,
  input  logic              irq_clr,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic              card_end,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_empty,
  output logic [CNT_W-1:0]  rd_level,
  output logic              irq,
  output logic              busy,
  output logic              parity_err,
  output logic              lrc_err
);

  localparam int WW = $clog2(CHAR_W + 1);

  mstd_state_e       st_q, st_d;
  logic [1:0]        mode_q, mode_d;
  logic [CHAR_W-1:0] start_q, start_d;
  logic [WW-1:0]     bcnt_q, bcnt_d;
  logic [CNT_W-1:0]  ccnt_q, ccnt_d;
  logic [CHAR_W-1:0] lrc_q, lrc_d;
  logic              irq_q, irq_d, perr_q, perr_d, lerr_q, lerr_d;

  logic [WW-1:0]     width;
  logic [CNT_W-1:0]  max_chars;
  logic [CHAR_W-1:0] wmask, win_nx, ch_data, lrc_next;
  logic              filled_nx, par_ok, push, clear, fifo_full;

  always_comb begin
    case (mode_q)
      MODE_W5: begin width = WW'(NARROW_W); max_chars = CNT_W'(MAX_W5); end
      MODE_W7: begin width = WW'(MID_W);    max_chars = CNT_W'(MAX_W7); end
      default: begin width = WW'(CHAR_W);   max_chars = CNT_W'(MAX_W8); end
    endcase
    wmask = {CHAR_W{1'b1}} >> (WW'(CHAR_W) - width);
  end

  mstd_bit_window #(.CHAR_W(CHAR_W), .WW(WW)) window_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .width     (width),
    .win_nx    (win_nx),
    .filled_nx (filled_nx)
  );

  mstd_char_check #(.CHAR_W(CHAR_W), .WW(WW)) check_i (
    .ch     (win_nx),
    .width  (width),
    .par_ok (par_ok),
    .data   (ch_data)
  );

  mstd_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH), .LW(CNT_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .push      (push),
    .push_data (win_nx),
    .pop       (rd_en),
    .rd_data   (rd_data),
    .empty     (rd_empty),
    .full      (fifo_full),
    .level     (rd_level)
  );

  assign lrc_next = lrc_q ^ ch_data;

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    start_d = start_q;
    bcnt_d  = bcnt_q;
    ccnt_d  = ccnt_q;
    lrc_d   = lrc_q;
    irq_d   = irq_q;
    perr_d  = perr_q;
    lerr_d  = lerr_q;
    push    = 1'b0;
    clear   = 1'b0;

    if (cfg_we && st_q == ST_IDLE) begin
      mode_d  = cfg_mode;
      start_d = cfg_start;
    end
    if (irq_clr) irq_d = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (arm && !irq_q) begin
          clear  = 1'b1;
          st_d   = ST_HUNT;
          bcnt_d = '0;
          ccnt_d = '0;
          lrc_d  = '0;
          perr_d = 1'b0;
          lerr_d = 1'b0;
        end
      end
      ST_HUNT: begin
        if (bit_valid && filled_nx && win_nx == (start_q & wmask)) begin
          push   = 1'b1;
          st_d   = ST_COLLECT;
          bcnt_d = '0;
          ccnt_d = CNT_W'(1);
          lrc_d  = ch_data;
          if (!par_ok) perr_d = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (bit_valid) begin
          if (bcnt_q == width - WW'(1)) begin
            push   = 1'b1;
            bcnt_d = '0;
            ccnt_d = ccnt_q + CNT_W'(1);
            lrc_d  = lrc_next;
            if (!par_ok) perr_d = 1'b1;
            if (ccnt_q + CNT_W'(1) == max_chars) begin
              st_d   = ST_IDLE;
              irq_d  = 1'b1;
              lerr_d = (lrc_next != '0);
            end
          end else begin
            bcnt_d = bcnt_q + WW'(1);
          end
        end else if (card_end) begin
          st_d   = ST_IDLE;
          irq_d  = 1'b1;
          lerr_d = (lrc_q != '0);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= MODE_W8;
      start_q <= '0;
      bcnt_q  <= '0;
      ccnt_q  <= '0;
      lrc_q   <= '0;
      irq_q   <= 1'b0;
      perr_q  <= 1'b0;
      lerr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      start_q <= start_d;
      bcnt_q  <= bcnt_d;
      ccnt_q  <= ccnt_d;
      lrc_q   <= lrc_d;
      irq_q   <= irq_d;
      perr_q  <= perr_d;
      lerr_q  <= lerr_d;
    end
  end

  assign irq        = irq_q;
  assign busy       = (st_q != ST_IDLE);
  assign parity_err = perr_q;
  assign lrc_err    = lerr_q;

  // R1: configuration holds while a card is in progress
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(mode_q) && $stable(start_q)));

  // R3: an arm request with the interrupt pending leaves the block idle
  p_arm_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && arm && st_q == ST_IDLE) |=> (st_q == ST_IDLE));

  // R4: bit position inside a character stays below the width
  p_bit_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLLECT) |-> (bcnt_q < width));

  // R6: collection never sits at or past the character limit
  p_char_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLLECT) |-> (ccnt_q < max_chars && ccnt_q != '0));

endmodule

// File: tb/mstd_track_decoder_tb.sv
module mstd_track_decoder_tb_top;

  logic       clk, rst_n;
  logic       cfg_we, arm, irq_clr, bit_valid, bit_data, card_end, rd_en;
  logic [1:0] cfg_mode;
  logic [7:0] cfg_start, rd_data;
  logic [6:0] rd_level;
  logic       rd_empty, irq, busy, parity_err, lrc_err;

  int n_chk, n_err;
  bit finished;

  logic [7:0] exp_c [0:127];
  int         exp_n;
  logic [7:0] xacc;

  mstd_track_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_start(cfg_start), .arm(arm), .irq_clr(irq_clr),
    .bit_valid(bit_valid), .bit_data(bit_data), .card_end(card_end),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
    .rd_level(rd_level), .irq(irq), .busy(busy),
    .parity_err(parity_err), .lrc_err(lrc_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic int width_of(input logic [1:0] m);
    return (m == 2'd1) ? 5 : (m == 2'd2) ? 7 : 8;
  endfunction

  function automatic int max_of(input logic [1:0] m);
    return (m == 2'd1) ? 40 : (m == 2'd2) ? 79 : 72;
  endfunction

  function automatic logic [7:0] dmask(input int w);
    return 8'((1 << (w - 1)) - 1);
  endfunction

  function automatic logic [7:0] mk_char(input logic [7:0] d, input int w);
    logic [7:0] dd;
    dd = d & dmask(w);
    return dd | (8'(~^dd) << (w - 1));
  endfunction

  function automatic logic [7:0] sentinel(input logic [1:0] m);
    return (m == 2'd1) ? mk_char(8'h0B, 5) : (m == 2'd2) ? mk_char(8'h05, 7) : mk_char(8'h25, 8);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_data = b;
    @(negedge clk); bit_valid = 1'b0; bit_data = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] c, input int w);
    for (int i = 0; i < w; i++) send_bit(c[i]);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [7:0] s);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m; cfg_start = s;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); card_end = 1'b1;
    @(negedge clk); card_end = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic add_exp(input logic [7:0] c, input int w);
    exp_c[exp_n] = c;
    exp_n++;
    xacc ^= c & dmask(w);
  endtask

  // sends leading zeros, the sentinel, ndata characters, optional check char
  task automatic send_card(input logic [1:0] m, input int ndata, input bit with_lrc,
                           input bit bad_lrc, input int bad_par_at);
    int w;
    logic [7:0] c;
    w = width_of(m);
    exp_n = 0;
    xacc = 8'h00;
    for (int i = 0; i < int'($urandom_range(0, 9)); i++) send_bit(1'b0);
    c = sentinel(m);
    send_char(c, w);
    add_exp(c, w);
    for (int i = 0; i < ndata; i++) begin
      c = mk_char(8'($urandom), w);
      if (i == bad_par_at) c ^= 8'(1 << (w - 1));
      send_char(c, w);
      add_exp(c, w);
    end
    if (with_lrc) begin
      c = mk_char(xacc ^ {7'd0, bad_lrc}, w);
      send_char(c, w);
      add_exp(c, w);
    end
  endtask

  task automatic drain_check(input string req);
    check({req, " level"}, 32'(rd_level), 32'(exp_n));
    for (int i = 0; i < exp_n; i++) begin
      check({req, " char"}, 32'(rd_data), 32'(exp_c[i]));
      pop();
    end
    check({req, " empty"}, 32'(rd_empty), 32'd1);
  endtask

  task automatic arm_mode(input logic [1:0] m);
    if (irq) pulse_clr();
    set_cfg(m, sentinel(m));
    pulse_arm();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1357));
    n_chk = 0; n_err = 0; finished = 1'b0;
    rst_n = 1'b0; cfg_we = 0; cfg_mode = 0; cfg_start = 0; arm = 0; irq_clr = 0;
    bit_valid = 0; bit_data = 0; card_end = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 irq", 32'(irq), 0);
    check("R10 busy", 32'(busy), 0);
    check("R10 parity_err", 32'(parity_err), 0);
    check("R10 lrc_err", 32'(lrc_err), 0);
    check("R10 empty", 32'(rd_empty), 1);

    // R9 pop on empty ignored
    pop();
    check("R9 pop empty level", 32'(rd_level), 0);

    // R2 R4 R5 R8: 5-bit card; end during hunt ignored; partial tail dropped
    arm_mode(2'd1);
    check("R2 busy after arm", 32'(busy), 1);
    pulse_end();
    check("R5 end in hunt busy", 32'(busy), 1);
    check("R5 end in hunt irq", 32'(irq), 0);
    send_card(2'd1, 6, 1'b1, 1'b0, -1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    check("R5 no irq before end", 32'(irq), 0);
    pulse_end();
    check("R5 irq", 32'(irq), 1);
    check("R5 busy", 32'(busy), 0);
    check("R8 lrc ok", 32'(lrc_err), 0);
    check("R7 parity ok", 32'(parity_err), 0);

    // R3 arm refused while irq pending; FIFO untouched
    pulse_arm();
    check("R3 arm refused busy", 32'(busy), 0);
    check("R3 arm refused level", 32'(rd_level), 32'(exp_n));
    drain_check("R4 5-bit card");
    pulse_clr();
    check("R3 irq cleared", 32'(irq), 0);

    // R8 bad check char in 7-bit mode
    arm_mode(2'd2);
    send_card(2'd2, 9, 1'b1, 1'b1, -1);
    pulse_end();
    check("R8 lrc error", 32'(lrc_err), 1);
    check("R7 parity ok 7", 32'(parity_err), 0);
    drain_check("R4 7-bit card");

    // R7 parity error, then arm clears flags and FIFO (R9)
    arm_mode(2'd1);
    send_card(2'd1, 5, 1'b1, 1'b0, 2);
    pulse_end();
    check("R7 parity error", 32'(parity_err), 1);
    pulse_clr();
    pulse_arm();
    check("R7 cleared by arm", 32'(parity_err), 0);
    check("R9 cleared by arm", 32'(rd_empty), 1);
    pulse_end();
    check("R5 end in hunt again", 32'(busy), 1);

    // R1 config write while busy ignored: stays 5-bit
    set_cfg(2'd0, sentinel(2'd0));
    send_card(2'd1, 4, 1'b1, 1'b0, -1);
    pulse_end();
    check("R1 cfg ignored irq", 32'(irq), 1);
    check("R1 cfg ignored lrc", 32'(lrc_err), 0);
    drain_check("R1 cfg ignored");

    // R6 limit in 5-bit mode
    arm_mode(2'd1);
    send_card(2'd1, 39, 1'b0, 1'b0, -1);
    check("R6 auto finish irq", 32'(irq), 1);
    check("R6 auto finish busy", 32'(busy), 0);
    check("R8 lrc at limit", 32'(lrc_err), 32'(xacc != 8'h00));
    send_char(mk_char(8'h3, 5), 5);
    drain_check("R6 limit 40");

    // R1 mode 3 behaves as 8-bit
    arm_mode(2'd3);
    send_card(2'd0, 3, 1'b1, 1'b0, -1);
    pulse_end();
    check("R1 mode3 lrc", 32'(lrc_err), 0);
    drain_check("R1 mode3 8-bit");

    // random cards across modes
    for (int k = 0; k < 8; k++) begin
      logic [1:0] m;
      bit bl;
      int nd;
      m  = 2'($urandom_range(0, 2));
      bl = 1'($urandom);
      nd = $urandom_range(1, 20);
      arm_mode(m);
      send_card(m, nd, 1'b1, bl, -1);
      pulse_end();
      check("R5 rand irq", 32'(irq), 1);
      check("R8 rand lrc", 32'(lrc_err), 32'(bl));
      check("R7 rand parity", 32'(parity_err), 0);
      drain_check("R4 rand card");
      if (max_of(m) < 0) check("R6 unreachable", 0, 0);
    end

    summary();
  end

endmodule